// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller for an 8-bit successive-approximation converter that sits behind an 8-way analog input selector. A 3-bit channel number is captured when the address strobe rises, and the block drives a one-hot select to the external switches. A pulse on the start pin clears the converter's state. When that pulse ends, a fixed schedule counted in clocks begins. The comparator is first auto-zeroed, then the chosen input is sampled, and then eight bit trials run from MSB to LSB, seven clocks each. The trial code leaves the block as two 4-bit halves, one for a coarse DAC section and one for a fine DAC section. A single comparator bit comes back.

At clock 67 of the schedule the finished code moves into a result register and the end-of-conversion flag rises. The result bus shows that register whenever the output enable is high. The bus has no back-pressure. A result stays readable until the next conversion completes and is never consumed by a read. The enable pin only gates what the bus shows, and the bus-enable output tells the pad ring when to drive. A new start pulse during a conversion abandons the current conversion and starts the schedule again.

Top module: `sar_conv_seq`

## Requirements
- R1: On each clock edge where `ale` is high and was low on the previous edge, `addr` is captured, and `ch_sel` becomes one-hot with bit n set for captured value n (000 gives bit 0, 111 gives bit 7). A change of `addr` with no such edge leaves `ch_sel` unchanged. After reset `ch_sel` is 8'h01.
- R2: The edge where `start` is first seen high clears the trial code to zero and stops any running schedule. `dac_hi`/`dac_lo` read 0 after that edge, and the code stays zero through sampling.
- R3: The first edge where `start` is seen low again is clock 1. `az_en` is high after clocks 1, 2 and 3 and low otherwise. `az_en` and `samp_en` are never high together.
- R4: `samp_en` is high after clocks 4 through 7 and low after clock 8.
- R5: `eoc` goes low on clock 8. Before clock 8 it keeps its earlier value.
- R6: The trial for code bit 7-b starts on clock 8+7b, where that bit is set to 1. On clock 15+7b the bit takes the comparator value (1 = input at or above the DAC level). After clock 8 the code is 8'h80, and after clock 15 it is {decided bit 7, 1, 000000}. `dac_hi` carries code bits 7:4 and `dac_lo` carries bits 3:0.
- R7: On clock 67 the final code is loaded into the result register and `eoc` rises. The result equals the input value seen by the comparator.
- R8: The result register holds its value, including through a later conversion, until that conversion reaches clock 67.
- R9: `db_en` follows `oe`. `db_data` shows the result while `oe` is high and reads 0 while `oe` is low.
- R10: A start pulse during a conversion abandons it. `eoc` stays low until the restarted conversion reaches its own clock 67, and the result then reflects the restarted conversion.
- R11: Full-scale inputs convert exactly: an input of 8'hFF gives 8'hFF and an input of 8'h00 gives 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ale | input | 1 | Address strobe; its rising edge captures `addr` |
| addr | input | 3 | Channel number |
| start | input | 1 | Start pulse: high clears, low again begins |
| oe | input | 1 | Result bus output enable |
| cmp_in | input | 1 | Comparator: 1 when input is at or above DAC level |
| ch_sel | output | 8 | One-hot analog input select |
| az_en | output | 1 | Comparator auto-zero control |
| samp_en | output | 1 | Sampling window |
| dac_hi | output | 4 | Trial code bits 7:4 to coarse DAC section |
| dac_lo | output | 4 | Trial code bits 3:0 to fine DAC section |
| eoc | output | 1 | End of conversion, high when result valid |
| db_data | output | 8 | Result bus, 0 when not enabled |
| db_en | output | 1 | Bus drive enable |

## Verification
Two events share one clock edge in every conversion: the decision of one bit and the setting of the next lower bit. For example, clock 15 both settles bit 7 from the comparator and raises bit 6. The bench drives a comparator model that reads a stored input value. It checks that the trial code after clock 15 holds the decided MSB together with the newly raised bit 6, for inputs on both sides of mid-scale. The final result is then compared with the stored input for codes at both ends of the range and at mid-scale.

// File: rtl/sar_seq_pkg.sv
`timescale 1ns/1ps
package sar_seq_pkg;
  localparam int CODE_W    = 8;
  localparam int CH_W      = 3;
  localparam int AZ_CLKS   = 4;
  localparam int SMP_CLKS  = 4;
  localparam int SLOT_CLKS = 7;
  localparam int TAIL_CLKS = 3;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_AZ,
    PH_SAMP,
    PH_TRIAL,
    PH_TAIL
  } seq_phase_e;
endpackage

// File: rtl/sar_chan_latch.sv
`timescale 1ns/1ps
module sar_chan_latch #(
  parameter int CH_W = sar_seq_pkg::CH_W,
  localparam int NCH = 1 << CH_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ale,
  input  logic [CH_W-1:0] addr,
  output logic [NCH-1:0]  ch_sel
);
  logic            ale_q;
  logic [CH_W-1:0] ch_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ale_q <= 1'b0;
      ch_q  <= '0;
    end else begin
      ale_q <= ale;
      if (ale && !ale_q) ch_q <= addr;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_dec
    assign ch_sel[g] = (ch_q == CH_W'(g));
  end
endmodule

// File: rtl/sar_timer.sv
`timescale 1ns/1ps
module sar_timer
  import sar_seq_pkg::*;
#(
  parameter int CODE_W    = sar_seq_pkg::CODE_W,
  parameter int AZ_CLKS   = sar_seq_pkg::AZ_CLKS,
  parameter int SMP_CLKS  = sar_seq_pkg::SMP_CLKS,
  parameter int SLOT_CLKS = sar_seq_pkg::SLOT_CLKS,
  parameter int TAIL_CLKS = sar_seq_pkg::TAIL_CLKS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output seq_phase_e        phase,
  output logic              clr,
  output logic              eoc_clr,
  output logic              done,
  output logic [CODE_W-1:0] set_vec,
  output logic [CODE_W-1:0] dec_vec
);
  localparam int PRE       = AZ_CLKS + SMP_CLKS;
  localparam int TRIAL_END = PRE + CODE_W * SLOT_CLKS;
  localparam int DONE_CLK  = TRIAL_END + TAIL_CLKS;
  localparam int CW        = $clog2(DONE_CLK + 1);

  logic          start_q;
  logic          run;
  logic [CW-1:0] cnt;
  logic          fall;
  logic          adv;

  assign clr  = start && !start_q;
  assign fall = !start && start_q;
  assign adv  = run && !clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      run     <= 1'b0;
      cnt     <= '0;
    end else begin
      start_q <= start;
      if (clr) begin
        run <= 1'b0;
        cnt <= '0;
      end else if (fall) begin
        run <= 1'b1;
        cnt <= CW'(1);
      end else if (adv) begin
        if (cnt == CW'(DONE_CLK - 1)) begin
          run <= 1'b0;
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    if (!run)                        phase = PH_IDLE;
    else if (cnt < CW'(AZ_CLKS))     phase = PH_AZ;
    else if (cnt < CW'(PRE))         phase = PH_SAMP;
    else if (cnt < CW'(TRIAL_END))   phase = PH_TRIAL;
    else                             phase = PH_TAIL;
  end

  assign eoc_clr = adv && (cnt == CW'(PRE - 1));
  assign done    = adv && (cnt == CW'(DONE_CLK - 1));

  for (genvar i = 0; i < CODE_W; i++) begin : g_slot
    localparam int SLOT = CODE_W - 1 - i;
    assign set_vec[i] = adv && (cnt == CW'(PRE - 1 + SLOT * SLOT_CLKS));
    assign dec_vec[i] = adv && (cnt == CW'(PRE - 1 + (SLOT + 1) * SLOT_CLKS));
  end
endmodule

// File: rtl/sar_bit_reg.sv
`timescale 1ns/1ps
module sar_bit_reg #(
  parameter int CODE_W = sar_seq_pkg::CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [CODE_W-1:0] set_vec,
  input  logic [CODE_W-1:0] dec_vec,
  input  logic              cmp_in,
  output logic [CODE_W-1:0] code
);
  for (genvar i = 0; i < CODE_W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n || clr)   code[i] <= 1'b0;
      else if (set_vec[i]) code[i] <= 1'b1;
      else if (dec_vec[i]) code[i] <= cmp_in;
    end
  end
endmodule

// File: rtl/sar_result.sv
`timescale 1ns/1ps
module sar_result #(
  parameter int CODE_W = sar_seq_pkg::CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic              eoc_clr,
  input  logic [CODE_W-1:0] code,
  input  logic              oe,
  output logic              eoc,
  output logic [CODE_W-1:0] db_data,
  output logic              db_en
);
  logic [CODE_W-1:0] res_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eoc   <= 1'b1;
      res_q <= '0;
    end else if (done) begin
      eoc   <= 1'b1;
      res_q <= code;
    end else if (eoc_clr) begin
      eoc   <= 1'b0;
    end
  end

  assign db_data = oe ? res_q : '0;
  assign db_en   = oe;
endmodule

// File: rtl/sar_conv_seq.sv
`timescale 1ns/1ps
module sar_conv_seq
  import sar_seq_pkg::*;
#(
  parameter int CODE_W    = sar_seq_pkg::CODE_W,
  parameter int CH_W      = sar_seq_pkg::CH_W,
  parameter int AZ_CLKS   = sar_seq_pkg::AZ_CLKS,
  parameter int SMP_CLKS  = sar_seq_pkg::SMP_CLKS,
  parameter int SLOT_CLKS = sar_seq_pkg::SLOT_CLKS,
  parameter int TAIL_CLKS = sar_seq_pkg::TAIL_CLKS,
  localparam int NCH      = 1 << CH_W,
  localparam int HI_W     = CODE_W / 2,
  localparam int LO_W     = CODE_W - HI_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale,
  input  logic [CH_W-1:0]   addr,
  input  logic              start,
  input  logic              oe,
  input  logic              cmp_in,
  output logic [NCH-1:0]    ch_sel,
  output logic              az_en,
  output logic              samp_en,
  output logic [HI_W-1:0]   dac_hi,
  output logic [LO_W-1:0]   dac_lo,
  output logic              eoc,
  output logic [CODE_W-1:0] db_data,
  output logic              db_en
);
  seq_phase_e        phase;
  logic              clr;
  logic              eoc_clr;
  logic              done;
  logic [CODE_W-1:0] set_vec;
  logic [CODE_W-1:0] dec_vec;
  logic [CODE_W-1:0] code;

  sar_chan_latch #(.CH_W(CH_W)) u_chan (
    .clk(clk), .rst_n(rst_n), .ale(ale), .addr(addr), .ch_sel(ch_sel)
  );

  sar_timer #(
    .CODE_W(CODE_W), .AZ_CLKS(AZ_CLKS), .SMP_CLKS(SMP_CLKS),
    .SLOT_CLKS(SLOT_CLKS), .TAIL_CLKS(TAIL_CLKS)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .phase(phase), .clr(clr),
    .eoc_clr(eoc_clr), .done(done), .set_vec(set_vec), .dec_vec(dec_vec)
  );

  sar_bit_reg #(.CODE_W(CODE_W)) u_bits (
    .clk(clk), .rst_n(rst_n), .clr(clr), .set_vec(set_vec),
    .dec_vec(dec_vec), .cmp_in(cmp_in), .code(code)
  );

  sar_result #(.CODE_W(CODE_W)) u_res (
    .clk(clk), .rst_n(rst_n), .done(done), .eoc_clr(eoc_clr), .code(code),
    .oe(oe), .eoc(eoc), .db_data(db_data), .db_en(db_en)
  );

  assign az_en   = (phase == PH_AZ);
  assign samp_en = (phase == PH_SAMP);
  assign dac_hi  = code[CODE_W-1:LO_W];
  assign dac_lo  = code[LO_W-1:0];
endmodule

// File: rtl/sar_conv_seq_chk.sv
`timescale 1ns/1ps
module sar_conv_seq_chk #(
  parameter int CODE_W = 8,
  parameter int NCH    = 8,
  parameter int HI_W   = 4,
  parameter int LO_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              oe,
  input logic [NCH-1:0]    ch_sel,
  input logic              az_en,
  input logic              samp_en,
  input logic [HI_W-1:0]   dac_hi,
  input logic [LO_W-1:0]   dac_lo,
  input logic              eoc,
  input logic [CODE_W-1:0] db_data
);
  p_sel_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ch_sel) == 1);

  p_code_clear_samp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    samp_en |-> ({dac_hi, dac_lo} == '0));

  p_az_samp_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(az_en && samp_en));

  p_eoc_fall_after_samp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eoc) |-> $past(samp_en));

  p_eoc_rise_loads_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(eoc) && oe) |-> (db_data == {dac_hi, dac_lo} && !az_en && !samp_en));

  p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (oe && $past(oe) && eoc && $past(eoc)) |-> $stable(db_data));
endmodule

bind sar_conv_seq sar_conv_seq_chk #(
  .CODE_W(CODE_W), .NCH(NCH), .HI_W(HI_W), .LO_W(LO_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .oe(oe), .ch_sel(ch_sel), .az_en(az_en),
  .samp_en(samp_en), .dac_hi(dac_hi), .dac_lo(dac_lo), .eoc(eoc),
  .db_data(db_data)
);

// File: tb/sim_sar_conv_seq.sv
`timescale 1ns/1ps
module sim_sar_conv_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ale = 1'b0;
  logic [2:0] addr = '0;
  logic       start = 1'b0;
  logic       oe = 1'b0;
  logic       cmp_in;
  logic [7:0] ch_sel;
  logic       az_en, samp_en, eoc, db_en;
  logic [3:0] dac_hi, dac_lo;
  logic [7:0] db_data;

  logic [7:0] analog [8];
  logic [7:0] sel_val;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sar_conv_seq u0 (
    .clk(clk), .rst_n(rst_n), .ale(ale), .addr(addr), .start(start), .oe(oe),
    .cmp_in(cmp_in), .ch_sel(ch_sel), .az_en(az_en), .samp_en(samp_en),
    .dac_hi(dac_hi), .dac_lo(dac_lo), .eoc(eoc), .db_data(db_data), .db_en(db_en)
  );

  always_comb begin
    sel_val = 8'h00;
    for (int j = 0; j < 8; j++) if (ch_sel[j]) sel_val = analog[j];
    cmp_in = (sel_val >= {dac_hi, dac_lo});
  end

  // {channel, input value}
  localparam int NV = 6;
  localparam logic [10:0] VEC [NV] = '{
    {3'd0, 8'h00}, {3'd7, 8'hFF}, {3'd3, 8'h80},
    {3'd5, 8'h7F}, {3'd2, 8'h55}, {3'd6, 8'hA3}
  };

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic latch_addr(input logic [2:0] a);
    @(negedge clk) addr = a;
    @(negedge clk) ale = 1'b1;
    @(negedge clk) ale = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  // Next rising edge is clock 1 of the schedule.
  task automatic run_conv(input logic [7:0] vin, input logic [7:0] prev, input logic eoc0);
    for (int k = 1; k <= 67; k++) begin
      @(posedge clk);
      @(negedge clk);
      case (k)
        3: chk(az_en && !samp_en, "R3 az_en after clock 3", {az_en, samp_en}, 2'b10);
        4: chk(!az_en && samp_en, "R4 samp_en after clock 4", {az_en, samp_en}, 2'b01);
        7: begin
          chk(samp_en, "R4 samp_en after clock 7", samp_en, 1);
          chk(eoc == eoc0, "R5 eoc before clock 8", eoc, eoc0);
        end
        8: begin
          chk(!eoc && !samp_en, "R5 eoc low at clock 8", {eoc, samp_en}, 0);
          chk({dac_hi, dac_lo} == 8'h80, "R6 first trial code", {dac_hi, dac_lo}, 8'h80);
        end
        15: chk({dac_hi, dac_lo} == {vin[7], 7'h40}, "R6 MSB decided and bit 6 set",
                {dac_hi, dac_lo}, {vin[7], 7'h40});
        66: begin
          chk(!eoc, "R10 eoc low at clock 66", eoc, 0);
          chk(db_data == prev, "R8 previous result held", db_data, prev);
        end
        67: begin
          chk(eoc, "R7 eoc high at clock 67", eoc, 1);
          chk(db_data == vin, "R7 R11 result equals input", db_data, vin);
        end
        default: ;
      endcase
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] prev;
    for (int j = 0; j < 8; j++) analog[j] = 8'(j * 37 + 11);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk(eoc, "R7 eoc high after reset", eoc, 1);
    chk(ch_sel == 8'h01, "R1 ch_sel after reset", ch_sel, 8'h01);
    chk({dac_hi, dac_lo} == 8'h00, "R2 code after reset", {dac_hi, dac_lo}, 0);
    chk(!az_en && !samp_en, "R3 idle controls after reset", {az_en, samp_en}, 0);
    chk(db_data == 8'h00 && !db_en, "R9 bus off after reset", {db_en, db_data}, 0);

    // table of conversions
    oe = 1'b1;
    prev = 8'h00;
    for (int v = 0; v < NV; v++) begin
      logic [2:0] a;
      logic [7:0] val;
      a = VEC[v][10:8];
      val = VEC[v][7:0];
      for (int j = 0; j < 8; j++) analog[j] = 8'(j * 37 + 11);
      analog[a] = val;
      latch_addr(a);
      @(negedge clk);
      chk(ch_sel == (8'h01 << a), "R1 channel select", ch_sel, 8'h01 << a);
      pulse_start();
      run_conv(val, prev, 1'b1);
      prev = val;
    end

    // R1: address change without strobe is ignored
    addr = 3'd1;
    repeat (3) @(negedge clk);
    chk(ch_sel == 8'h40, "R1 addr ignored without strobe", ch_sel, 8'h40);

    // R9: output enable gating
    oe = 1'b0;
    @(negedge clk);
    chk(db_data == 8'h00 && !db_en, "R9 bus off with oe low", {db_en, db_data}, 0);
    oe = 1'b1;
    @(negedge clk);
    chk(db_data == 8'hA3 && db_en, "R9 bus on with oe high", {db_en, db_data}, 9'h1A3);

    // R8: result held while idle
    repeat (20) @(negedge clk);
    chk(db_data == 8'hA3, "R8 result held while idle", db_data, 8'hA3);

    // R10 / R2: abort and restart
    analog[6] = 8'h3C;
    pulse_start();
    repeat (30) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    chk({dac_hi, dac_lo} == 8'h00, "R2 start clears code", {dac_hi, dac_lo}, 0);
    chk(!eoc, "R10 eoc stays low on abort", eoc, 0);
    analog[6] = 8'hC5;
    start = 1'b0;
    run_conv(8'hC5, 8'hA3, 1'b0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule